// File: doc/BRIEF.md
# Serial DAC Load Controller

A host-side controller that loads one channel of an eight-channel, 8-bit serial DAC over a three-wire link (serial clock, serial data, active-low select). A single-cycle request carries a 3-bit channel number, an 8-bit code and a flag asking for a reset pulse first. The controller optionally pulses the DAC's active-low reset line. It then drops the select, shifts a 16-bit word: an address byte followed by the code byte, most significant bit first. It raises the select again after the last bit, and that rising edge makes the DAC take the new value.

The serial clock runs at one thirty-second of the system clock, idles low, and data changes only while it is low, so every bit is steady across the rising edge. Shutdown is held inactive at all times. Status is a busy level and a one-cycle done pulse. A request that arrives while busy is dropped.

Top module: `dac_load_ctrl`

## Requirements
- R1: After reset and whenever busy_o is low, cs_n_o and rs_n_o are 1 and sclk_o and sdi_o are 0.
- R2: An accepted request holds cs_n_o low for exactly 512 system cycles (16 serial clock periods) with exactly 16 rising sclk_o edges, and cs_n_o falls while sclk_o is low.
- R3: The first 8 bits shifted are the address byte: five 0 bits, then addr_i[2], addr_i[1], addr_i[0].
- R4: The last 8 bits shifted are data_i from bit 7 down to bit 0, and sdi_o is constant while sclk_o is high.
- R5: sclk_o has a period of 32 system cycles: 16 cycles low, then 16 cycles high, and it is high only while cs_n_o is low.
- R6: With rst_first_i set, rs_n_o is low for 32 cycles starting the cycle after acceptance, then high for 32 cycles before cs_n_o falls; with it clear, rs_n_o stays 1.
- R7: done_o is 1 for exactly one cycle, the first cycle in which cs_n_o is high again after a frame.
- R8: busy_o rises the cycle after acceptance and falls 32 cycles after cs_n_o rises; req_i is accepted only while busy_o is low, and otherwise has no effect.
- R9: shdn_n_o is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Write request strobe |
| addr_i | input | 3 | DAC channel number |
| data_i | input | 8 | DAC code |
| rst_first_i | input | 1 | Pulse the DAC reset before the frame |
| sclk_o | output | 1 | Serial clock |
| sdi_o | output | 1 | Serial data to the DAC |
| cs_n_o | output | 1 | Active-low chip select |
| rs_n_o | output | 1 | Active-low DAC reset |
| shdn_n_o | output | 1 | Active-low DAC shutdown, held high |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at commit |

## Verification
The hardest case to reach is a request that lands exactly on the boundary where the inter-frame gap ends. The old transfer must finish cleanly, and the new one must start on the first idle cycle and not one cycle early. The bench reaches it by holding req_i high through a whole frame and its gap. It also fires single-cycle requests with different fields in the middle of a frame and during the reset pulse. A cycle-exact reference queue then shows the dropped fields never appear on sdi_o and that the held request starts on the first idle edge.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LO,
    ST_RST_GAP,
    ST_SHIFT,
    ST_GAP
  } state_e;
endpackage

// File: rtl/period_timer.sv
module period_timer #(
  parameter int CLK_DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic wrap_o,
  output logic high_o
);
  localparam int CNT_W = $clog2(CLK_DIV);
  localparam int HALF  = CLK_DIV / 2;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = run_i && (cnt_q == CNT_W'(CLK_DIV - 1));
  assign high_o = run_i && (cnt_q >= CNT_W'(HALF));
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               shift_i,
  output logic               msb_o,
  output logic               last_o
);
  localparam int BC_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sr_q;
  logic [BC_W-1:0]    bc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
      bc_q <= '0;
    end else if (load_i) begin
      sr_q <= word_i;
      bc_q <= '0;
    end else if (shift_i) begin
      sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
      bc_q <= bc_q + 1'b1;
    end
  end

  assign msb_o  = sr_q[FRAME_W-1];
  assign last_o = (bc_q == BC_W'(FRAME_W - 1));
endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl #(
  parameter int CLK_DIV = 32,
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rst_first_i,
  output logic              sclk_o,
  output logic              sdi_o,
  output logic              cs_n_o,
  output logic              rs_n_o,
  output logic              shdn_n_o,
  output logic              busy_o,
  output logic              done_o
);
  import dac_load_pkg::*;

  localparam int FRAME_W = 2 * DATA_W;
  localparam int PAD_W   = DATA_W - ADDR_W;

  state_e state_q, state_d;
  logic   done_q;
  logic   wrap, high, msb, last;
  logic   accept, load, shift;

  assign accept = (state_q == ST_IDLE) && req_i;
  assign load   = accept;
  assign shift  = (state_q == ST_SHIFT) && wrap && !last;

  period_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .wrap_o (wrap),
    .high_o (high)
  );

  frame_shifter #(.FRAME_W(FRAME_W)) u_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .word_i  ({{PAD_W{1'b0}}, addr_i, data_i}),
    .shift_i (shift),
    .msb_o   (msb),
    .last_o  (last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i) state_d = rst_first_i ? ST_RST_LO : ST_SHIFT;
      ST_RST_LO:  if (wrap)  state_d = ST_RST_GAP;
      ST_RST_GAP: if (wrap)  state_d = ST_SHIFT;
      ST_SHIFT:   if (wrap && last) state_d = ST_GAP;
      ST_GAP:     if (wrap)  state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_SHIFT) && wrap && last;
    end
  end

  assign cs_n_o   = (state_q != ST_SHIFT);
  assign rs_n_o   = (state_q != ST_RST_LO);
  assign sclk_o   = (state_q == ST_SHIFT) && high;
  assign sdi_o    = (state_q == ST_SHIFT) && msb;
  assign shdn_n_o = 1'b1;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
endmodule

// File: rtl/dac_load_ctrl_checker.sv
module dac_load_ctrl_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic sdi_o,
  input logic cs_n_o,
  input logic rs_n_o,
  input logic shdn_n_o,
  input logic busy_o,
  input logic done_o
);
  a_r1_idle_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_n_o && rs_n_o && !sclk_o && !sdi_o));

  a_r2_cs_falls_clk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> !sclk_o);

  a_r4_sdi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdi_o));

  a_r5_clk_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_n_o);

  a_r6_reset_outside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rs_n_o |-> cs_n_o);

  a_r7_done_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($rose(cs_n_o) && busy_o));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_shdn_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_n_o);
endmodule

bind dac_load_ctrl dac_load_ctrl_checker u_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sclk_o   (sclk_o),
  .sdi_o    (sdi_o),
  .cs_n_o   (cs_n_o),
  .rs_n_o   (rs_n_o),
  .shdn_n_o (shdn_n_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/dac_load_ctrl_bench.sv
module dac_load_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] data = '0;
  logic       rf = 1'b0;
  logic sclk, sdi, cs_n, rs_n, shdn_n, busy, done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dac_load_ctrl u_dac_load_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .data_i(data),
    .rst_first_i(rf), .sclk_o(sclk), .sdi_o(sdi), .cs_n_o(cs_n), .rs_n_o(rs_n),
    .shdn_n_o(shdn_n), .busy_o(busy), .done_o(done)
  );

  // expected vector: {sclk, sdi, cs_n, rs_n, done, busy}
  typedef logic [5:0] vec_t;
  localparam vec_t IDLE_V = 6'b001100;
  vec_t q[$];
  logic [15:0] wq[$];
  vec_t cur = IDLE_V;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      if (fails < 30) $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: queue of per-cycle outputs after each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); wq.delete(); cur = IDLE_V;
    end else begin
      if (!cur[0] && req) begin
        logic [15:0] w;
        w = {5'b0, addr, data};
        wq.push_back(w);
        if (rf) begin
          for (int c = 0; c < 32; c++) q.push_back(6'b001001);
          for (int c = 0; c < 32; c++) q.push_back(6'b001101);
        end
        for (int b = 0; b < 16; b++)
          for (int c = 0; c < 32; c++)
            q.push_back({(c >= 16) ? 1'b1 : 1'b0, w[15-b], 1'b0, 1'b1, 1'b0, 1'b1});
        for (int c = 0; c < 32; c++) q.push_back({4'b0011, (c == 0) ? 1'b1 : 1'b0, 1'b1});
      end
      if (q.size() > 0) cur = q.pop_front();
      else cur = IDLE_V;
    end
  end

  // per-cycle comparison and frame capture, away from the active edge
  logic [15:0] cap = '0;
  int edges = 0;
  logic sclk_prev = 1'b0;
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R5 sclk", sclk, cur[5]);
      check("R4 sdi", sdi, cur[4]);
      check("R2 cs_n", cs_n, cur[3]);
      check("R6 rs_n", rs_n, cur[2]);
      check("R7 done", done, cur[1]);
      check("R8 busy", busy, cur[0]);
      check("R9 shdn_n", shdn_n, 1'b1);
      if (sclk && !sclk_prev) begin
        cap = {cap[14:0], sdi};
        edges++;
      end
      if (done) begin
        logic [15:0] w;
        w = (wq.size() > 0) ? wq.pop_front() : 16'hxxxx;
        check("R2 edge count", edges, 16);
        check("R3 address byte", cap[15:8], w[15:8]);
        check("R4 data byte", cap[7:0], w[7:0]);
        edges = 0;
      end
    end
    sclk_prev = sclk;
  end

  task automatic write(input logic [2:0] a, input logic [7:0] d, input logic f);
    @(negedge clk);
    addr = a; data = d; rf = f; req = 1'b1;
    @(negedge clk);
    req = 1'b0; addr = ~a; data = ~d; rf = ~f;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 cs_n reset", cs_n, 1'b1);
    check("R1 rs_n reset", rs_n, 1'b1);
    check("R1 sclk reset", sclk, 1'b0);
    check("R1 sdi reset", sdi, 1'b0);
    check("R8 busy reset", busy, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    write(3'd5, 8'hA5, 1'b0); wait_idle();   // R3 R4 plain write
    write(3'd0, 8'h00, 1'b0); wait_idle();   // all-zero word
    write(3'd7, 8'hFF, 1'b1); wait_idle();   // R6 reset-first, all-ones fields

    // R8: requests during reset pulse and mid-frame are dropped
    write(3'd2, 8'h3C, 1'b1);
    repeat (10) @(negedge clk);
    write(3'd6, 8'hC3, 1'b0);
    repeat (200) @(negedge clk);
    write(3'd1, 8'h81, 1'b1);
    wait_idle();

    // R8: request held high across a frame and its gap
    @(negedge clk);
    addr = 3'd4; data = 8'h5A; rf = 1'b0; req = 1'b1;
    repeat (560) @(negedge clk);
    check("R8 busy during held request", busy, 1'b1);
    req = 1'b0;
    wait_idle();
    check("R1 idle cs_n after runs", cs_n, 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp=finish", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule